// File: doc/BRIEF.md
# Shared-Net Strength Resolver

The resolver works out the state of one shared net that several drivers feed. Each driver presents a level code and a 6-bit strength. Strength 0 means the driver is released (high impedance). Strength 63 is the forcing strength. Outputs with open collectors, tri-state enables and pull resistors are all expressed as drivers with suitable strengths. The resolver finds the strongest driver. It then compares that strength against the strongest driver that shows a different level. A run-time margin input decides whether the leader wins or the net becomes unknown. The net is flagged as floating when no driver has any strength.

The driver count is a parameter. The decision logic is combinational. One register stage holds the result behind a valid/ready handshake.

On the input side, a driver set is taken when `in_valid` and `in_ready` are both high in the same cycle. The result appears on the outputs one cycle later, with `out_valid` high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure passes through with no extra bubble. While `out_valid` is high and `out_ready` is low, the outputs hold their values and `in_ready` stays low. The margin is sampled together with the driver set.

Top module: `strres_net`

## Requirements
- R1: Level codes are 0=000, 1=001, rising=010, falling=011, unknown=100. A driver code of 5 to 7 is read as unknown. `net_level` only ever carries codes 0 to 4.
- R2: The level of a driver at strength 0 has no effect on any output.
- R3: Suppose every driver with nonzero strength shows the same level, and the strongest strength S is at least the margin. Then the net takes that level at strength S.
- R4: Suppose the levels differ. Let S be the top strength and T the top strength among drivers whose level differs from the leader's. If S minus T is at least the margin, the net takes the leader's level at strength S.
- R5: When the margin in R3 or R4 is not met, the net level is unknown (100) and the net strength is S.
- R6: Suppose two drivers share the top strength with different levels. The net is unknown unless the margin is 0. With a margin of 0, the level of the lower-indexed of them wins.
- R7: When every driver is at strength 0, the output is level 100, strength 0 and `net_z`=1. `net_z` is 1 exactly when the net strength is 0.
- R8: `in_ready` is high when `out_valid` is low or `out_ready` is high. A set accepted at an edge shows on the outputs after that edge with `out_valid`=1. When `out_ready` is high and no set is accepted, `out_valid` falls.
- R9: While `out_valid`=1 and `out_ready`=0, all outputs stay unchanged.
- R10: After reset, `out_valid`=0, `net_level`=100, `net_str`=0 and `net_z`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Driver set present |
| in_ready | output | 1 | Resolver can take a set |
| drv_level | input | 3*N_DRV | Level codes, driver i at bits [3i+2:3i] |
| drv_str | input | 6*N_DRV | Strengths, driver i at bits [6i+5:6i] |
| ovr_margin | input | 6 | Overdrive margin |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| net_level | output | 3 | Resolved level code |
| net_str | output | 6 | Resolved strength |
| net_z | output | 1 | Net floating |

## Verification
A fault in the leader search or in the rival search shows one cycle after acceptance. Typical symptoms are a wrong strength, a driver at strength 0 that still sets the level, or a tie resolved to the wrong index. A fault in the margin compare shows up near the boundary, where S minus T equals the margin, so the sweep uses margins that land exactly on such differences. A fault in the handshake register shows as outputs that change during a stall, or as a valid flag that lingers one cycle after draining.

// File: rtl/strres_pkg.sv
package strres_pkg;
  localparam int STR_W = 6;
  localparam int LVL_W = 3;

  typedef enum logic [LVL_W-1:0] {
    LV_LO   = 3'd0,
    LV_HI   = 3'd1,
    LV_RISE = 3'd2,
    LV_FALL = 3'd3,
    LV_UNK  = 3'd4
  } lvl_e;

  typedef logic [STR_W-1:0] str_t;

  // codes above 4 are read as unknown (R1)
  function automatic lvl_e lvl_norm(input logic [LVL_W-1:0] code);
    lvl_e r;
    case (code)
      3'd0:    r = LV_LO;
      3'd1:    r = LV_HI;
      3'd2:    r = LV_RISE;
      3'd3:    r = LV_FALL;
      default: r = LV_UNK;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strres_lead.sv
module strres_lead
  import strres_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic [N_DRV-1:0][LVL_W-1:0] lvl,
  input  logic [N_DRV-1:0][STR_W-1:0] str,
  output str_t                        top_str,
  output lvl_e                        top_lvl
);
  // strict compare keeps the lowest index on a tie (R6)
  always_comb begin
    top_str = '0;
    top_lvl = LV_UNK;
    for (int i = 0; i < N_DRV; i++) begin
      if (str[i] > top_str) begin
        top_str = str[i];
        top_lvl = lvl_norm(lvl[i]);
      end
    end
  end
endmodule

// File: rtl/strres_rival.sv
module strres_rival
  import strres_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic [N_DRV-1:0][LVL_W-1:0] lvl,
  input  logic [N_DRV-1:0][STR_W-1:0] str,
  input  lvl_e                        top_lvl,
  output str_t                        rival_str
);
  // strongest active driver that disagrees with the leader (R2, R4)
  always_comb begin
    rival_str = '0;
    for (int i = 0; i < N_DRV; i++) begin
      if ((str[i] != '0) && (lvl_norm(lvl[i]) != top_lvl) &&
          (str[i] > rival_str))
        rival_str = str[i];
    end
  end
endmodule

// File: rtl/strres_decide.sv
module strres_decide
  import strres_pkg::*;
(
  input  str_t top_str,
  input  lvl_e top_lvl,
  input  str_t rival_str,
  input  str_t margin,
  output lvl_e res_lvl,
  output str_t res_str,
  output logic res_z
);
  str_t gap;

  always_comb begin
    gap     = top_str - rival_str;
    res_z   = (top_str == '0);
    res_str = top_str;
    if (res_z)
      res_lvl = LV_UNK;
    else if (gap >= margin)
      res_lvl = top_lvl;
    else
      res_lvl = LV_UNK;
  end
endmodule

// File: rtl/strres_net.sv
module strres_net
  import strres_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_DRV*LVL_W-1:0]   drv_level,
  input  logic [N_DRV*STR_W-1:0]   drv_str,
  input  logic [STR_W-1:0]         ovr_margin,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LVL_W-1:0]         net_level,
  output logic [STR_W-1:0]         net_str,
  output logic                     net_z
);
  logic [N_DRV-1:0][LVL_W-1:0] lvl_a;
  logic [N_DRV-1:0][STR_W-1:0] str_a;
  str_t top_str, rival_str, res_str;
  lvl_e top_lvl, res_lvl;
  logic res_z;
  logic take;

  assign lvl_a = drv_level;
  assign str_a = drv_str;

  strres_lead #(.N_DRV(N_DRV)) lead_i (
    .lvl(lvl_a), .str(str_a), .top_str(top_str), .top_lvl(top_lvl)
  );

  strres_rival #(.N_DRV(N_DRV)) rival_i (
    .lvl(lvl_a), .str(str_a), .top_lvl(top_lvl), .rival_str(rival_str)
  );

  strres_decide decide_i (
    .top_str(top_str), .top_lvl(top_lvl), .rival_str(rival_str),
    .margin(ovr_margin), .res_lvl(res_lvl), .res_str(res_str), .res_z(res_z)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      net_level <= LV_UNK;
      net_str   <= '0;
      net_z     <= 1'b1;
    end else if (take) begin
      out_valid <= 1'b1;
      net_level <= res_lvl;
      net_str   <= res_str;
      net_z     <= res_z;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/strres_chk.sv
module strres_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [2:0] net_level,
  input logic [5:0] net_str,
  input logic       net_z
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(net_level) &&
                                   $stable(net_str) && $stable(net_z)));

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R7
  z_vs_str_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (net_z == (net_str == 6'd0)));

  // R7
  z_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_z |-> (net_level == 3'd4));

  // R1
  legal_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_level <= 3'd4);
endmodule

bind strres_net strres_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .net_level(net_level),
  .net_str(net_str), .net_z(net_z)
);

// File: tb/strres_net_tb_top.sv
module strres_net_tb_top;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [NB*3-1:0] drv_level = '0;
  logic [NB*6-1:0] drv_str = '0;
  logic [5:0] ovr_margin = '0;
  logic in_ready, out_valid, net_z;
  logic [2:0] net_level;
  logic [5:0] net_str;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  strres_net #(.N_DRV(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .drv_level(drv_level), .drv_str(drv_str), .ovr_margin(ovr_margin),
    .out_valid(out_valid), .out_ready(out_ready), .net_level(net_level),
    .net_str(net_str), .net_z(net_z)
  );

  function automatic logic [2:0] nlv(input logic [2:0] c);
    return (c > 3'd4) ? 3'd4 : c;
  endfunction

  // expected {level, strength, z} from R1..R7
  function automatic logic [9:0] model(input logic [NB*3-1:0] lv,
                                       input logic [NB*6-1:0] st,
                                       input logic [5:0] thr);
    int s1 = 0;
    int s2 = 0;
    logic [2:0] l1 = 3'd4;
    for (int i = 0; i < NB; i++)
      if (int'(st[i*6 +: 6]) > s1) begin
        s1 = int'(st[i*6 +: 6]);
        l1 = nlv(lv[i*3 +: 3]);
      end
    for (int i = 0; i < NB; i++)
      if (st[i*6 +: 6] != 0 && nlv(lv[i*3 +: 3]) != l1 && int'(st[i*6 +: 6]) > s2)
        s2 = int'(st[i*6 +: 6]);
    if (s1 == 0) return {3'd4, 6'd0, 1'b1};
    if (s1 - s2 >= int'(thr)) return {l1, 6'(s1), 1'b0};
    return {3'd4, 6'(s1), 1'b0};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    checks++;
    if (!out_valid || {net_level, net_str, net_z} !== exp) begin
      errors++;
      $display("FAIL %s: got lvl=%0d str=%0d z=%0b v=%0b, exp lvl=%0d str=%0d z=%0b v=1",
               req, net_level, net_str, net_z, out_valid, exp[9:7], exp[6:1], exp[0]);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b exp %0b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [NB*3-1:0] lv, input logic [NB*6-1:0] st,
                       input logic [5:0] thr, input string req);
    @(negedge clk);
    drv_level = lv; drv_str = st; ovr_margin = thr;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(req, model(lv, st, thr));
  endtask

  function automatic logic [5:0] spick(input int k);
    case (k)
      0: return 6'd0;
      1: return 6'd2;
      2: return 6'd9;
      default: return 6'd63;
    endcase
  endfunction

  function automatic logic [5:0] tpick(input int k);
    case (k)
      0: return 6'd0;
      1: return 6'd7;
      2: return 6'd54;
      default: return 6'd63;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NB*3-1:0] lv;
    logic [NB*6-1:0] st;
    string req;
    int s1, nz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_bit("R10 out_valid", out_valid, 1'b0);
    check_bit("R10 net_z", net_z, 1'b1);
    check_bit("R10 net_level", net_level == 3'd4, 1'b1);
    check_bit("R10 net_str", net_str == 6'd0, 1'b1);
    check_bit("R8 ready when empty", in_ready, 1'b1);

    // R2: released driver's level has no effect
    for (int c = 0; c < 8; c++)
      apply({3'd0, 3'd1, 3'(c)}, {6'd0, 6'd20, 6'd0}, 6'd5, "R2");

    // R6: tie at the top, margin 0 picks lower index, else unknown
    apply({3'd0, 3'd0, 3'd1}, {6'd0, 6'd30, 6'd30}, 6'd0, "R6");
    apply({3'd0, 3'd0, 3'd1}, {6'd0, 6'd30, 6'd30}, 6'd1, "R6");

    // sweep: levels 0..5 (5 exercises R1), four strengths, four margins
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 24; a++)
        for (int b = 0; b < 24; b++)
          for (int d = 0; d < 24; d++) begin
            lv = {3'(d % 6), 3'(b % 6), 3'(a % 6)};
            st = {spick(d / 6), spick(b / 6), spick(a / 6)};
            s1 = 0; nz = 0;
            for (int i = 0; i < NB; i++) begin
              if (int'(st[i*6 +: 6]) > s1) s1 = int'(st[i*6 +: 6]);
              if (st[i*6 +: 6] != 0 && lv[i*3 +: 3] > 3'd4) nz = 1;
            end
            if (s1 == 0) req = "R7";
            else if (nz != 0) req = "R1";
            else if (model(lv, st, tpick(t)) ==
                     {3'd4, 6'(s1), 1'b0}) req = "R5";
            else if (model(lv, st, 6'd0) == {3'd4, 6'(s1), 1'b0}) req = "R3";
            else req = "R4";
            apply(lv, st, tpick(t), req);
          end

    // R8/R9 back-pressure
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check_bit("R8 drained", out_valid, 1'b0);
    out_ready = 1'b0; in_valid = 1'b1;
    drv_level = {3'd0, 3'd0, 3'd1}; drv_str = {6'd0, 6'd0, 6'd40}; ovr_margin = 6'd3;
    @(negedge clk);
    check("R8 accept", {3'd1, 6'd40, 1'b0});
    check_bit("R8 blocked", in_ready, 1'b0);
    drv_level = {3'd0, 3'd0, 3'd3}; drv_str = {6'd0, 6'd0, 6'd12};
    @(negedge clk);
    check("R9 hold", {3'd1, 6'd40, 1'b0});
    @(negedge clk);
    check("R9 hold", {3'd1, 6'd40, 1'b0});
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 next", {3'd3, 6'd12, 1'b0});
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 empty", out_valid, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule